// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block decides, one cycle at a time, whether a five-stage in-order pipeline must hold its front end because the instruction now in decode needs a value that a load in execute has not yet fetched from data memory. It compares the source register indices of the decode instruction with the destination index of the instruction in execute. It does this only when the execute instruction is a memory read. A match on a source that the decode instruction really reads, other than register 0, is a load-use dependence.

On a dependence the unit drops the write enable of the program counter and the write enable of the fetch/decode pipeline register. The same instruction therefore stays in fetch and in decode. The unit also asserts a select that zeroes every control bit entering the decode/execute register. The slot moving forward is then a bubble that writes nothing and reads no memory.

The decision is purely combinational. In the next cycle the bubble sits in execute with its memory-read flag low, so the front end runs again and a dependent instruction pays exactly one cycle. The decoder upstream supplies the source-use flags. A jump reads no register. An immediate-type instruction reads only rs. A store reports rt as not read here, because the store-data path is served by forwarding in the memory stage.

Top module: `hzd_load_use`

## Requirements
- R1: When `ex_mem_rd` is 1, `dec_rs_used` is 1, `dec_rs` is nonzero and `dec_rs` equals `ex_rt`, then in the same cycle `pc_wr_en` is 0, `fd_wr_en` is 0 and `ctl_zero` is 1.
- R2: When `ex_mem_rd` is 1, `dec_rt_used` is 1, `dec_rt` is nonzero and `dec_rt` equals `ex_rt`, then in the same cycle the unit stalls (`pc_wr_en`=0, `fd_wr_en`=0, `ctl_zero`=1).
- R3: When `ex_mem_rd` is 0, the unit never stalls: `pc_wr_en`=1, `fd_wr_en`=1, `ctl_zero`=0, whatever the register indices are.
- R4: Register index 0 never causes a stall. With `ex_rt`=0, the outputs are `pc_wr_en`=1, `fd_wr_en`=1 and `ctl_zero`=0, even when a used source field is also 0.
- R5: A source whose use flag is 0 has no effect. A match on `dec_rs` with `dec_rs_used`=0, or on `dec_rt` with `dec_rt_used`=0, gives `pc_wr_en`=1 and `ctl_zero`=0 unless the other, used source matches. A store that gives its loaded register only as data (rt flag 0) raises no stall.
- R6: The outputs are always consistent with each other: `fd_wr_en` equals `pc_wr_en`, and `ctl_zero` is the inverse of `pc_wr_en`.
- R7: A load followed directly by a dependent instruction costs exactly one stall cycle. When the bubble reaches execute with `ex_mem_rd`=0, the enables return to 1 and `ctl_zero` returns to 0 while the held instruction is still in decode.
- R8: With no dependence, the unit asserts `pc_wr_en`=1, `fd_wr_en`=1 and `ctl_zero`=0 in the same cycle as its inputs. No state is kept between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | IDX_W (5) | First source register index of the decode instruction (instruction bits 25:21) |
| dec_rt | input | IDX_W (5) | Second source register index of the decode instruction (instruction bits 20:16) |
| dec_rs_used | input | 1 | Decode instruction reads the register named by `dec_rs` |
| dec_rt_used | input | 1 | Decode instruction reads the register named by `dec_rt` as an operand |
| ex_rt | input | IDX_W (5) | Destination register index of the instruction in execute (its bits 20:16) |
| ex_mem_rd | input | 1 | Instruction in execute reads data memory (a load) |
| pc_wr_en | output | 1 | Program counter may update; 0 holds it |
| fd_wr_en | output | 1 | Fetch/decode pipeline register may update; 0 holds it |
| ctl_zero | output | 1 | 1 selects all-zero control bits into the decode/execute register |

## Verification
The hardest situation to reach is the stall that comes back after exactly one cycle. It needs a load in execute whose destination is a used, nonzero source of the decode instruction. In the next cycle a bubble must sit in execute while the same instruction is still in decode. The bench drives this through a small pipeline model. The model puts a load into execute with its destination copied from a source field of the decode instruction. After the first stall it changes execute into a bubble, and it counts how many cycles the front end is held. Random stimulus draws register indices from a narrow range that includes 0. Matches, zero-register hits and masked sources therefore happen often next to the directed cases.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    // Per-cycle front-end control produced by the stall unit
    typedef struct packed {
        logic pc_we;     // program counter update enable
        logic fd_we;     // fetch/decode register update enable
        logic ctl_zero;  // zero the control bundle entering execute
    } hold_ctl_t;

    localparam hold_ctl_t HOLD_RUN   = '{pc_we: 1'b1, fd_we: 1'b1, ctl_zero: 1'b0};
    localparam hold_ctl_t HOLD_STALL = '{pc_we: 1'b0, fd_we: 1'b0, ctl_zero: 1'b1};

    // Map a stall decision onto the control bundle
    function automatic hold_ctl_t hold_from_stall(input logic stall);
        return stall ? HOLD_STALL : HOLD_RUN;
    endfunction

endpackage

// File: rtl/hzd_src_cmp.sv
// One source-versus-load comparator; register 0 never matches.
module hzd_src_cmp #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic             src_used,
    input  logic [IDX_W-1:0] load_dst,
    input  logic             load_vld,
    output logic             hit
);
    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic idx_eq;
    logic nonzero;

    always_comb begin
        idx_eq  = (src_idx == load_dst);
        nonzero = (load_dst != ZERO_IDX);
        hit     = load_vld && src_used && nonzero && idx_eq;
    end
endmodule

// File: rtl/hzd_stall_merge.sv
// Combines the per-source hits into the front-end control bundle.
module hzd_stall_merge
    import hzd_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] hits,
    output hold_ctl_t          ctl
);
    logic any_hit;

    always_comb begin
        any_hit = |hits;
        ctl     = hold_from_stall(any_hit);
    end
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use
    import hzd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] dec_rs,
    input  logic [IDX_W-1:0] dec_rt,
    input  logic             dec_rs_used,
    input  logic             dec_rt_used,
    input  logic [IDX_W-1:0] ex_rt,
    input  logic             ex_mem_rd,
    output logic             pc_wr_en,
    output logic             fd_wr_en,
    output logic             ctl_zero
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][IDX_W-1:0] src_idx;
    logic [NUM_SRC-1:0]            src_used;
    logic [NUM_SRC-1:0]            src_hit;
    hold_ctl_t                     ctl;

    always_comb begin
        src_idx[0]  = dec_rs;
        src_idx[1]  = dec_rt;
        src_used[0] = dec_rs_used;
        src_used[1] = dec_rt_used;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        hzd_src_cmp #(.IDX_W(IDX_W)) u_cmp (
            .src_idx  (src_idx[g]),
            .src_used (src_used[g]),
            .load_dst (ex_rt),
            .load_vld (ex_mem_rd),
            .hit      (src_hit[g])
        );
    end

    hzd_stall_merge #(.NUM_SRC(NUM_SRC)) u_merge (
        .hits (src_hit),
        .ctl  (ctl)
    );

    always_comb begin
        pc_wr_en = ctl.pc_we;
        fd_wr_en = ctl.fd_we;
        ctl_zero = ctl.ctl_zero;
    end
endmodule

// File: rtl/hzd_load_use_chk.sv
module hzd_load_use_chk #(
    parameter int IDX_W = 5
) (
    input logic [IDX_W-1:0] dec_rs,
    input logic [IDX_W-1:0] dec_rt,
    input logic             dec_rs_used,
    input logic             dec_rt_used,
    input logic [IDX_W-1:0] ex_rt,
    input logic             ex_mem_rd,
    input logic             pc_wr_en,
    input logic             fd_wr_en,
    input logic             ctl_zero
);
    always_comb begin
        // R1
        rs_dep_stall_chk: assert (!(ex_mem_rd && dec_rs_used && (ex_rt != '0) && (dec_rs == ex_rt))
                                  || (!pc_wr_en && !fd_wr_en && ctl_zero));
        // R2
        rt_dep_stall_chk: assert (!(ex_mem_rd && dec_rt_used && (ex_rt != '0) && (dec_rt == ex_rt))
                                  || (!pc_wr_en && !fd_wr_en && ctl_zero));
        // R3
        no_load_run_chk: assert (ex_mem_rd || (pc_wr_en && fd_wr_en && !ctl_zero));
        // R4
        zero_reg_run_chk: assert ((ex_rt != '0) || (pc_wr_en && !ctl_zero));
        // R5
        unused_src_run_chk: assert (dec_rs_used || dec_rt_used || (pc_wr_en && !ctl_zero));
        // R6
        outputs_agree_chk: assert ((fd_wr_en == pc_wr_en) && (ctl_zero == !pc_wr_en));
    end
endmodule

bind hzd_load_use hzd_load_use_chk #(.IDX_W(IDX_W)) u_hzd_chk (
    .dec_rs      (dec_rs),
    .dec_rt      (dec_rt),
    .dec_rs_used (dec_rs_used),
    .dec_rt_used (dec_rt_used),
    .ex_rt       (ex_rt),
    .ex_mem_rd   (ex_mem_rd),
    .pc_wr_en    (pc_wr_en),
    .fd_wr_en    (fd_wr_en),
    .ctl_zero    (ctl_zero)
);

// File: tb/test_hzd_load_use.sv
module test_hzd_load_use;
    localparam int IDX_W = 5;
    localparam int N_RAND = 400;

    logic             clk = 1'b0;
    logic [IDX_W-1:0] dec_rs = '0, dec_rt = '0, ex_rt = '0;
    logic             dec_rs_used = 1'b0, dec_rt_used = 1'b0, ex_mem_rd = 1'b0;
    logic             pc_wr_en, fd_wr_en, ctl_zero;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    hzd_load_use #(.IDX_W(IDX_W)) i_hzd_load_use (
        .dec_rs(dec_rs), .dec_rt(dec_rt), .dec_rs_used(dec_rs_used),
        .dec_rt_used(dec_rt_used), .ex_rt(ex_rt), .ex_mem_rd(ex_mem_rd),
        .pc_wr_en(pc_wr_en), .fd_wr_en(fd_wr_en), .ctl_zero(ctl_zero)
    );

    // Expected stall from the requirement text
    function automatic bit exp_stall(logic [IDX_W-1:0] rs, logic [IDX_W-1:0] rt,
                                     bit rsu, bit rtu, logic [IDX_W-1:0] dst, bit mrd);
        bit h_rs = rsu && (rs == dst);
        bit h_rt = rtu && (rt == dst);
        return mrd && (dst != 0) && (h_rs || h_rt);
    endfunction

    task automatic drive(logic [IDX_W-1:0] rs, logic [IDX_W-1:0] rt, bit rsu, bit rtu,
                         logic [IDX_W-1:0] dst, bit mrd);
        @(negedge clk);
        dec_rs = rs; dec_rt = rt; dec_rs_used = rsu; dec_rt_used = rtu;
        ex_rt = dst; ex_mem_rd = mrd;
        #2;
    endtask

    task automatic check(string req, bit stall);
        logic [2:0] got, exp;
        got = {pc_wr_en, fd_wr_en, ctl_zero};
        exp = stall ? 3'b001 : 3'b110;
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: {pc,fd,zero} actual %b expected %b (rs=%0d rt=%0d use=%b%b dst=%0d mrd=%b)",
                     req, got, exp, dec_rs, dec_rt, dec_rs_used, dec_rt_used, ex_rt, ex_mem_rd);
        end
    endtask

    task automatic dir(string req, logic [IDX_W-1:0] rs, logic [IDX_W-1:0] rt, bit rsu, bit rtu,
                       logic [IDX_W-1:0] dst, bit mrd);
        drive(rs, rt, rsu, rtu, dst, mrd);
        check(req, exp_stall(rs, rt, rsu, rtu, dst, mrd));
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R8: idle state, no dependence
        dir("R8", 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0);
        dir("R8", 5'd3, 5'd4, 1'b1, 1'b1, 5'd9, 1'b1);
        // R1: rs dependence
        dir("R1", 5'd7, 5'd2, 1'b1, 1'b1, 5'd7, 1'b1);
        dir("R1", 5'd31, 5'd0, 1'b1, 1'b0, 5'd31, 1'b1);
        // R2: rt dependence
        dir("R2", 5'd1, 5'd12, 1'b1, 1'b1, 5'd12, 1'b1);
        dir("R2", 5'd6, 5'd6, 1'b1, 1'b1, 5'd6, 1'b1);
        // R3: not a load
        dir("R3", 5'd7, 5'd7, 1'b1, 1'b1, 5'd7, 1'b0);
        // R4: register 0
        dir("R4", 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1);
        dir("R4", 5'd0, 5'd5, 1'b1, 1'b0, 5'd0, 1'b1);
        // R5: masked sources, store data through rt
        dir("R5", 5'd9, 5'd3, 1'b0, 1'b1, 5'd9, 1'b1);
        dir("R5", 5'd4, 5'd8, 1'b1, 1'b0, 5'd8, 1'b1);
        dir("R5", 5'd11, 5'd11, 1'b0, 1'b0, 5'd11, 1'b1);
        dir("R5", 5'd8, 5'd8, 1'b0, 1'b1, 5'd8, 1'b1);

        // R7: load then dependent instruction, modelled pipeline
        for (int k = 0; k < 20; k++) begin
            logic [IDX_W-1:0] rs, rt;
            bit use_rt;
            int held;
            rs = IDX_W'($urandom_range(1, 31));
            rt = IDX_W'($urandom_range(1, 31));
            use_rt = k[0];
            held = 0;
            drive(rs, rt, 1'b1, 1'b1, use_rt ? rt : rs, 1'b1);
            if (!pc_wr_en) held++;
            check("R7", 1'b1);
            // bubble now in execute, same instruction still in decode
            drive(rs, rt, 1'b1, 1'b1, 5'd0, 1'b0);
            if (!pc_wr_en) held++;
            check("R7", 1'b0);
            n_chk++;
            if (held != 1) begin
                n_fail++;
                $display("FAIL R7: stall cycles actual %0d expected 1", held);
            end
        end

        // Random mix over a narrow index range (R1 R2 R3 R4 R5 R6)
        for (int i = 0; i < N_RAND; i++) begin
            logic [IDX_W-1:0] rs, rt, dst;
            bit rsu, rtu, mrd;
            rs  = IDX_W'($urandom_range(0, 3));
            rt  = IDX_W'($urandom_range(0, 3));
            dst = IDX_W'($urandom_range(0, 3));
            rsu = 1'($urandom);
            rtu = 1'($urandom);
            mrd = ($urandom_range(0, 3) != 0);
            dir("R6", rs, rt, rsu, rtu, dst, mrd);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule